// File: doc/BRIEF.md
# CCD Electronic Shutter Sequencer

This block times the exposure of an interline CCD. It counts line strobes within each field and field strobes within each exposure period. From these counts it drives three outputs. The first is a substrate discharge pulse that empties the photodiodes. The second is a readout enable that gates the charge-transfer pulses. The third is a write enable that tells a frame store which fields carry a fresh image during long exposures.

A 9-bit load value sets the exposure, measured down from 0x1FF. In high-speed mode the difference `0x1FF - load` is the number of lines, counted from the start of a field, on which the sensor is drained. In low-speed mode the same difference, doubled, is the length of the accumulation period in fields. A flickerless mode picks a fixed drain length that depends on the video standard. A no-shutter mode drains nothing.

The load value, mode, standard and accumulation type are sampled only on a field strobe. A setting therefore never changes partway through a field.

Top module: `shut_seq`

## Requirements
- R1: After reset `sub_o` is 0, `read_en_o` is 1 and `wen_o` is 1.
- R2: `load_i`, `mode_i`, `pal_i` and `frame_acc_i` are sampled only in the cycle where `vd_i` is 1. A change between field strobes has no effect until the next field strobe.
- R3: In high-speed mode (`mode_i` = 2'b01), the first `0x1FF - load` line strobes after a field strobe each give exactly one 1-cycle `sub_o` pulse, in the cycle after the strobe. Later line strobes in that field give none.
- R4: In flickerless mode (`mode_i` = 2'b00), the drain length is 105 lines when `pal_i` = 0 and 182 lines when `pal_i` = 1, regardless of `load_i`.
- R5: In high-speed, flickerless and no-shutter (`mode_i` = 2'b11) modes, `read_en_o` and `wen_o` are 1 in every field. In no-shutter mode `sub_o` never pulses.
- R6: In low-speed mode (`mode_i` = 2'b10) with `frame_acc_i` = 0, fields are grouped into periods of `2*(0x1FF - load)` fields. `read_en_o` is 1 only in the last field of each period. No `sub_o` pulse is issued. The first period begins at the field where low-speed mode is entered.
- R7: In low-speed field accumulation, `wen_o` is 1 exactly in the field that directly follows a field with `read_en_o` = 1, and 0 in every other field.
- R8: In low-speed mode, a load value whose low 8 bits are 0xFF is illegal. It is treated as 0x1FE, which gives a 2-field period.
- R9: In low-speed mode with `frame_acc_i` = 1, `load_i` is ignored. `read_en_o` and `wen_o` are 1 in every field and `sub_o` stays 0.
- R10: `read_en_o` and `wen_o` change only in the cycle after a field strobe. They hold their values for the rest of the field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Line strobe, one cycle per line |
| vd_i | input | 1 | Field strobe, one cycle per field; restarts the line count |
| load_i | input | 9 | Exposure load value |
| mode_i | input | 2 | 00 flickerless, 01 high-speed, 10 low-speed, 11 no shutter |
| pal_i | input | 1 | 0 selects the 525-line standard, 1 selects the 625-line standard |
| frame_acc_i | input | 1 | 1 selects frame accumulation |
| sub_o | output | 1 | Substrate discharge pulse |
| read_en_o | output | 1 | Readout enable for the current field |
| wen_o | output | 1 | Frame-store write enable for the current field |

## Verification
A wrong line count or latched drain length shows up as a wrong number of `sub_o` pulses within the very first field after the setting is taken. The error is visible at the first line strobe where a pulse appears or is missing. A field counter that wraps at the wrong point, or that fails to restart, shifts the `read_en_o` pattern. That shift shows in the field right after the wrong wrap. A stale previous-readout flag shows up as `wen_o` in the wrong field one field later. Mid-field changes to the settings are checked by sampling every output after each line strobe of the affected field.

// File: rtl/shut_pkg.sv
package shut_pkg;
  typedef enum logic [1:0] {
    MODE_FLK  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_OFF  = 2'b11
  } shut_mode_e;
endpackage

// File: rtl/shut_cfg.sv
module shut_cfg
  import shut_pkg::*;
#(
  parameter int LOAD_W        = 9,
  parameter int FLK_STOP_NTSC = 105,
  parameter int FLK_STOP_PAL  = 182
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vd_i,
  input  logic [LOAD_W-1:0] load_i,
  input  logic [1:0]        mode_i,
  input  logic              pal_i,
  input  logic              frame_acc_i,
  output logic [LOAD_W-1:0] stop_o,
  output logic              slow_nxt_o,
  output logic [LOAD_W:0]   last_nxt_o,
  output logic              slow_o,
  output logic [LOAD_W:0]   last_o
);
  localparam int BYTE_W = 8;
  localparam logic [LOAD_W-1:0] LOAD_ALL  = '1;
  localparam logic [LOAD_W-1:0] LOAD_SAFE = LOAD_ALL - 1'b1;

  shut_mode_e        mode;
  logic [LOAD_W-1:0] ld_fix, diff, stop_nxt;

  assign mode = shut_mode_e'(mode_i);

  // illegal low byte falls back to the shortest slow period
  assign ld_fix     = (load_i[BYTE_W-1:0] == '1) ? LOAD_SAFE : load_i;
  assign diff       = LOAD_ALL - ld_fix;
  assign last_nxt_o = {diff, 1'b0} - {{LOAD_W{1'b0}}, 1'b1};
  assign slow_nxt_o = (mode == MODE_SLOW) && !frame_acc_i;

  always_comb begin
    unique case (mode)
      MODE_FLK:  stop_nxt = pal_i ? LOAD_W'(FLK_STOP_PAL) : LOAD_W'(FLK_STOP_NTSC);
      MODE_HIGH: stop_nxt = LOAD_ALL - load_i;
      default:   stop_nxt = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_o <= '0;
      slow_o <= 1'b0;
      last_o <= '0;
    end else if (vd_i) begin
      stop_o <= stop_nxt;
      slow_o <= slow_nxt_o;
      last_o <= last_nxt_o;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_i |=> $stable(stop_o) && $stable(slow_o) && $stable(last_o)); // R2
  AST_SLOW_NO_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |-> stop_o == '0); // R6
endmodule

// File: rtl/shut_line.sv
module shut_line #(
  parameter int LOAD_W = 9,
  parameter int LINE_W = LOAD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_i,
  input  logic              vd_i,
  input  logic [LOAD_W-1:0] stop_i,
  output logic              sub_o
);
  localparam logic [LINE_W-1:0] LINE_SAT = '1;

  logic [LINE_W-1:0] line_cnt;
  logic [LINE_W-1:0] stop_ext;

  assign stop_ext = LINE_W'(stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_cnt <= '0;
      sub_o    <= 1'b0;
    end else begin
      sub_o <= hd_i && !vd_i && (line_cnt < stop_ext);
      if (vd_i)                             line_cnt <= '0;
      else if (hd_i && line_cnt != LINE_SAT) line_cnt <= line_cnt + 1'b1;
    end
  end

  AST_SUB_ON_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_o |-> $past(hd_i)); // R3
  AST_SUB_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_o && !hd_i) |=> !sub_o); // R3
  AST_QUIET_NO_SUB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i == '0) |=> !sub_o); // R5
endmodule

// File: rtl/shut_field.sv
module shut_field #(
  parameter int LOAD_W = 9,
  parameter int FLD_W  = LOAD_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vd_i,
  input  logic             slow_nxt_i,
  input  logic [FLD_W-1:0] last_nxt_i,
  input  logic             slow_i,
  input  logic [FLD_W-1:0] last_i,
  output logic             read_en_o,
  output logic             wen_o
);
  logic [FLD_W-1:0] fld_cnt, fld_nxt;

  // count continues only while low-speed field accumulation persists
  assign fld_nxt = (slow_i && slow_nxt_i && fld_cnt < last_nxt_i) ? fld_cnt + 1'b1 : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_cnt   <= '0;
      read_en_o <= 1'b1;
      wen_o     <= 1'b1;
    end else if (vd_i) begin
      if (slow_nxt_i) begin
        fld_cnt   <= fld_nxt;
        read_en_o <= (fld_nxt == last_nxt_i);
        wen_o     <= read_en_o;
      end else begin
        fld_cnt   <= '0;
        read_en_o <= 1'b1;
        wen_o     <= 1'b1;
      end
    end
  end

  AST_FLD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_i |-> fld_cnt <= last_i); // R6
  AST_WEN_READ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_i |-> !(wen_o && read_en_o)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vd_i |=> $stable(read_en_o) && $stable(wen_o)); // R10
  AST_NORMAL_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vd_i && !slow_nxt_i) |=> read_en_o && wen_o); // R5
endmodule

// File: rtl/shut_seq.sv
module shut_seq #(
  parameter int LOAD_W        = 9,
  parameter int FLK_STOP_NTSC = 105,
  parameter int FLK_STOP_PAL  = 182
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hd_i,
  input  logic              vd_i,
  input  logic [LOAD_W-1:0] load_i,
  input  logic [1:0]        mode_i,
  input  logic              pal_i,
  input  logic              frame_acc_i,
  output logic              sub_o,
  output logic              read_en_o,
  output logic              wen_o
);
  localparam int LINE_W = LOAD_W + 1;
  localparam int FLD_W  = LOAD_W + 1;

  logic [LOAD_W-1:0] stop;
  logic              slow_nxt, slow;
  logic [FLD_W-1:0]  last_nxt, last;

  shut_cfg #(
    .LOAD_W(LOAD_W), .FLK_STOP_NTSC(FLK_STOP_NTSC), .FLK_STOP_PAL(FLK_STOP_PAL)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .vd_i(vd_i), .load_i(load_i), .mode_i(mode_i),
    .pal_i(pal_i), .frame_acc_i(frame_acc_i), .stop_o(stop), .slow_nxt_o(slow_nxt),
    .last_nxt_o(last_nxt), .slow_o(slow), .last_o(last)
  );

  shut_line #(.LOAD_W(LOAD_W), .LINE_W(LINE_W)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .hd_i(hd_i), .vd_i(vd_i), .stop_i(stop), .sub_o(sub_o)
  );

  shut_field #(.LOAD_W(LOAD_W), .FLD_W(FLD_W)) u_field (
    .clk_i(clk_i), .rst_ni(rst_ni), .vd_i(vd_i), .slow_nxt_i(slow_nxt), .last_nxt_i(last_nxt),
    .slow_i(slow), .last_i(last), .read_en_o(read_en_o), .wen_o(wen_o)
  );

  AST_RESET_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> read_en_o && wen_o && !sub_o); // R1
endmodule

// File: tb/shut_seq_bench.sv
module shut_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hd = 1'b0, vd = 1'b0;
  logic [8:0] load = 9'h1FF;
  logic [1:0] mode = 2'b11;
  logic       pal = 1'b0, frame_acc = 1'b0;
  logic       sub, read_en, wen;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  shut_seq u_shut_seq (
    .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .vd_i(vd), .load_i(load), .mode_i(mode),
    .pal_i(pal), .frame_acc_i(frame_acc), .sub_o(sub), .read_en_o(read_en), .wen_o(wen)
  );

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe_vd();
    @(negedge clk); vd = 1'b1;
    @(negedge clk); vd = 1'b0;
  endtask

  task automatic line(output bit got);
    @(negedge clk); hd = 1'b1;
    @(negedge clk); hd = 1'b0; got = sub;
    @(negedge clk); check_eq("R3 pulse width", sub, 0);
  endtask

  // one field: strobe, then lines; counts drain pulses and checks output hold
  task automatic run_field(int lines, output int pulses, output bit rd, output bit we,
                           input int first_exp = -1);
    bit g;
    strobe_vd();
    rd = read_en; we = wen; pulses = 0;
    for (int i = 0; i < lines; i++) begin
      line(g);
      pulses += g;
      if (first_exp >= 0) check_eq("R3 line position", g, (i < first_exp) ? 1 : 0);
      check_eq("R10 read hold", read_en, rd);
      check_eq("R10 wen hold", wen, we);
    end
  endtask

  task automatic t_reset();
    check_eq("R1 sub", sub, 0);
    check_eq("R1 read", read_en, 1);
    check_eq("R1 wen", wen, 1);
  endtask

  task automatic t_high();
    int p; bit r, w;
    mode = 2'b01; load = 9'h1FA;
    run_field(10, p, r, w, 5);
    check_eq("R3 count", p, 5);
    check_eq("R5 read high-speed", r, 1);
    check_eq("R5 wen high-speed", w, 1);
    load = 9'h1FF;
    run_field(4, p, r, w);
    check_eq("R3 zero drain", p, 0);
  endtask

  task automatic t_midfield();
    int p; bit r, w; bit g;
    mode = 2'b01; load = 9'h1FA;
    strobe_vd();
    p = 0;
    for (int i = 0; i < 10; i++) begin
      if (i == 2) begin load = 9'h1F0; mode = 2'b11; end
      line(g); p += g;
    end
    check_eq("R2 mid-field change ignored", p, 5);
    mode = 2'b01;
    run_field(20, p, r, w, 15);
    check_eq("R2 new value at next field", p, 15);
  endtask

  task automatic t_flicker();
    int p; bit r, w;
    mode = 2'b00; load = 9'h1FA; pal = 1'b0;
    run_field(200, p, r, w);
    check_eq("R4 525-line drain", p, 105);
    check_eq("R5 read flickerless", r, 1);
    pal = 1'b1;
    run_field(200, p, r, w);
    check_eq("R4 625-line drain", p, 182);
    pal = 1'b0;
  endtask

  task automatic t_off();
    int p; bit r, w;
    mode = 2'b11; load = 9'h100;
    run_field(10, p, r, w);
    check_eq("R5 no drain", p, 0);
    check_eq("R5 read off", r, 1);
    check_eq("R5 wen off", w, 1);
  endtask

  task automatic t_slow();
    int p; bit r, w;
    mode = 2'b10; load = 9'h1FD; frame_acc = 1'b0;
    for (int k = 0; k < 9; k++) begin
      run_field(2, p, r, w);
      check_eq("R6 read pattern", r, ((k % 4) == 3) ? 1 : 0);
      check_eq("R7 wen pattern", w, ((k % 4) == 0) ? 1 : 0);
      check_eq("R6 no drain", p, 0);
    end
  endtask

  task automatic t_illegal(logic [8:0] ld);
    int p; bit r, w;
    mode = 2'b11;
    run_field(1, p, r, w);
    mode = 2'b10; load = ld;
    for (int k = 0; k < 4; k++) begin
      run_field(1, p, r, w);
      check_eq("R8 read pattern", r, k % 2);
      check_eq("R8 wen pattern", w, 1 - (k % 2));
    end
  endtask

  task automatic t_frame();
    int p; bit r, w;
    mode = 2'b10; load = 9'h1FD; frame_acc = 1'b1;
    for (int k = 0; k < 3; k++) begin
      run_field(3, p, r, w);
      check_eq("R9 read", r, 1);
      check_eq("R9 wen", w, 1);
      check_eq("R9 no drain", p, 0);
    end
    frame_acc = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_high();
    t_midfield();
    t_flicker();
    t_off();
    t_slow();
    t_illegal(9'h0FF);
    t_illegal(9'h1FF);
    t_frame();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule